// File: doc/BRIEF.md
# HMAC Sequencing Controller

This controller produces a keyed-hash message authentication tag by steering an external hash-compression engine. It does not compute any hash function itself. After a start pulse it collects a key of 0 to 128 bytes and a message, both as byte streams with valid/ready handshakes. It derives the 64-byte block key and forms the inner and outer keyed pad blocks. It then sends the engine a sequence of single-block operations and returns the truncated tag with a one-cycle done pulse.

Each engine operation carries five items: a 64-byte block, a chaining state to continue from, the count of bytes already hashed, the number of valid bytes in the block, and a flag that marks the final piece. With these, a hash can be split across operations. The two pad blocks are hashed on their own and their states are kept. The message is then hashed as a continuation of the inner state, and the inner digest as a continuation of the outer state. The count sent with each message block includes the 64-byte pad prefix, so the engine's length field covers the whole inner input.

Top module: `hmac_seq_ctrl`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `req_valid_o`, `key_ready_o` and `msg_ready_o` are low and `tag_o` is zero.
- R2: `start_i` is taken only while `busy_o` is low. `busy_o` is high from the cycle after the start until done. A start pulse while busy has no effect on the tag or on the operations issued. `done_o` lasts exactly one cycle, and `busy_o` is low when it is high.
- R3: For a key of 64 bytes or fewer, the derived key is the key bytes followed by zero bytes up to 64 bytes, with key byte 0 in the most significant byte of the block. No key hash operation is issued.
- R4: For a key longer than 64 bytes, two operations hash it before anything else. The first carries key bytes 0 to 63, state zero, count 0, 64 valid bytes and not final. The second carries the rest of the key, continues from the first digest, and has count 64 and the final flag set. The derived key is the first L bytes of the resulting digest, followed by zeros.
- R5: The inner pad block is the derived key XOR 0x36 in every byte, and the outer pad block is the derived key XOR 0x5c in every byte. The inner pad operation is issued first, then the outer pad operation. Both have state zero, count 0, 64 valid bytes and are not final.
- R6: The message is sent in 64-byte blocks, each continuing from the previous inner state. Each block's count is 64 plus the message bytes sent before it. Only the last block has the final flag set. Bytes past a block's valid count are zero. An empty message is sent as one final operation with 0 valid bytes.
- R7: The last operation carries the first L bytes of the inner digest followed by zeros. It continues from the saved outer state, with count 64, L valid bytes and the final flag set.
- R8: Mode 0 gives L=20, mode 1 gives L=28, and modes 2 and 3 give L=32. `tag_o` holds the first L bytes of the final digest, and its remaining bytes are zero.
- R9: `req_valid_o` is a one-cycle pulse. All request fields stay unchanged until `rsp_valid_i` answers it.
- R10: The digest at `rsp_digest_i` and at `tag_o` has byte 0 in bits 255:248.
- R11: `key_ready_o` is high only while key bytes remain, and exactly `key_len_i` bytes are taken. `msg_ready_o` is high only while message bytes remain, and exactly `msg_len_i` bytes are taken. Bytes offered outside these windows are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a tag computation |
| mode_i | input | 2 | Digest size select (0:20, 1:28, 2/3:32 bytes) |
| key_len_i | input | 8 | Key length in bytes, 0 to 128 |
| msg_len_i | input | LEN_W | Message length in bytes |
| key_valid_i | input | 1 | Key byte valid |
| key_data_i | input | 8 | Key byte |
| key_ready_o | output | 1 | Key byte accepted |
| msg_valid_i | input | 1 | Message byte valid |
| msg_data_i | input | 8 | Message byte |
| msg_ready_o | output | 1 | Message byte accepted |
| req_valid_o | output | 1 | Engine operation request pulse |
| req_block_o | output | 512 | Block bytes, byte 0 in MSBs |
| req_state_o | output | 256 | Chaining state to continue from (zero when fresh) |
| req_count_o | output | LEN_W+1 | Bytes hashed before this block |
| req_nbytes_o | output | 7 | Valid bytes in the block |
| req_last_o | output | 1 | Final piece, engine pads and finishes |
| req_mode_o | output | 2 | Digest mode for the engine |
| rsp_valid_i | input | 1 | Engine result valid |
| rsp_digest_i | input | 256 | Engine result state or digest |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | Tag valid, one cycle |
| tag_o | output | 256 | Tag, first L bytes significant |

## Verification
The bench sweeps key lengths of 0, 5, 64, 65 and 128 bytes against message lengths of 0, 1, 64, 65 and 129 bytes, in all four modes. The key lengths separate the empty, short, exact and hashed key paths. The message lengths separate the empty message, a partial block, an exact block and the carry into further blocks. A mock engine folds every request field into its result, so a wrong count, byte position, pad constant, order or chaining state changes the tag. The bench compares that tag with a model of the same flow. Random gaps on both byte streams, bytes still offered after each stream ends, and start pulses while busy show that only the intended bytes and starts are taken.

// File: rtl/hmac_pkg.sv
package hmac_pkg;
  localparam int BLK_BYTES = 64;
  localparam int DIG_BYTES = 32;
  localparam int KEY_BYTES = 2 * BLK_BYTES;
  localparam int BLK_W     = 8 * BLK_BYTES;
  localparam int DIG_W     = 8 * DIG_BYTES;
  localparam int KEY_W     = 8 * KEY_BYTES;
  localparam int KL_W      = $clog2(KEY_BYTES + 1);
  localparam int KI_W      = $clog2(KEY_BYTES);
  localparam int NB_W      = $clog2(BLK_BYTES + 1);
  localparam int BI_W      = $clog2(BLK_BYTES);

  typedef enum logic [2:0] {ST_IDLE, ST_KEY, ST_MSG, ST_REQ, ST_WAIT} st_e;
  typedef enum logic [2:0] {OP_KEY0, OP_KEY1, OP_IPAD, OP_OPAD, OP_MSG, OP_OUT} op_e;

  function automatic int unsigned dig_len(input logic [1:0] mode);
    case (mode)
      2'd0:    return 20;
      2'd1:    return 28;
      default: return 32;
    endcase
  endfunction

  function automatic logic [DIG_W-1:0] dig_mask(input logic [1:0] mode);
    return ~({DIG_W{1'b1}} >> (8 * dig_len(mode)));
  endfunction
endpackage

// File: rtl/hmac_byte_buf.sv
module hmac_byte_buf #(
  parameter int NBYTES = 64,
  localparam int IW = $clog2(NBYTES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  wr_i,
  input  logic [IW-1:0]         idx_i,
  input  logic [7:0]            byte_i,
  output logic [8*NBYTES-1:0]   data_o
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    logic [7:0] b_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            b_q <= '0;
      else if (clr_i)                         b_q <= '0;
      else if (wr_i && idx_i == IW'(g))       b_q <= byte_i;
    end
    assign data_o[8*(NBYTES-g)-1 -: 8] = b_q;
  end
endmodule

// File: rtl/hmac_pad_gen.sv
module hmac_pad_gen
  import hmac_pkg::*;
(
  input  logic [BLK_W-1:0] key_blk_i,
  input  logic [DIG_W-1:0] key_dig_i,
  input  logic             long_i,
  input  logic [1:0]       mode_i,
  output logic [BLK_W-1:0] ipad_o,
  output logic [BLK_W-1:0] opad_o
);
  logic [BLK_W-1:0] k0;
  assign k0 = long_i ? {key_dig_i & dig_mask(mode_i), {(BLK_W-DIG_W){1'b0}}} : key_blk_i;

  for (genvar g = 0; g < BLK_BYTES; g++) begin : g_pad
    assign ipad_o[8*g +: 8] = k0[8*g +: 8] ^ 8'h36;
    assign opad_o[8*g +: 8] = k0[8*g +: 8] ^ 8'h5c;
  end
endmodule

// File: rtl/hmac_seq_ctrl.sv
module hmac_seq_ctrl
  import hmac_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [1:0]         mode_i,
  input  logic [KL_W-1:0]    key_len_i,
  input  logic [LEN_W-1:0]   msg_len_i,
  input  logic               key_valid_i,
  input  logic [7:0]         key_data_i,
  output logic               key_ready_o,
  input  logic               msg_valid_i,
  input  logic [7:0]         msg_data_i,
  output logic               msg_ready_o,
  output logic               req_valid_o,
  output logic [BLK_W-1:0]   req_block_o,
  output logic [DIG_W-1:0]   req_state_o,
  output logic [LEN_W:0]     req_count_o,
  output logic [NB_W-1:0]    req_nbytes_o,
  output logic               req_last_o,
  output logic [1:0]         req_mode_o,
  input  logic               rsp_valid_i,
  input  logic [DIG_W-1:0]   rsp_digest_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [DIG_W-1:0]   tag_o
);
  st_e               state_q;
  op_e               op_q;
  logic [1:0]        mode_q;
  logic [KL_W-1:0]   klen_q, kcnt_q;
  logic [LEN_W-1:0]  mlen_q, base_q;
  logic [NB_W-1:0]   fill_q;
  logic [DIG_W-1:0]  chain_q, kdig_q, sin_q, sout_q, tag_q;
  logic              done_q;

  logic              take_start, key_hs, msg_hs, key_long, msg_last, mbuf_clr;
  logic [KEY_W-1:0]  kbuf;
  logic [BLK_W-1:0]  mbuf, ipad, opad;
  logic [DIG_W-1:0]  mask;

  assign take_start  = (state_q == ST_IDLE) && start_i;
  assign key_ready_o = (state_q == ST_KEY);
  assign msg_ready_o = (state_q == ST_MSG);
  assign key_hs      = key_ready_o && key_valid_i;
  assign msg_hs      = msg_ready_o && msg_valid_i;
  assign key_long    = klen_q > KL_W'(BLK_BYTES);
  assign msg_last    = (base_q + LEN_W'(fill_q)) == mlen_q;
  assign mask        = dig_mask(mode_q);
  assign mbuf_clr    = take_start ||
                       (state_q == ST_WAIT && rsp_valid_i && op_q == OP_MSG && !msg_last);

  hmac_byte_buf #(.NBYTES(KEY_BYTES)) u_key_buf (
    .clk_i, .rst_ni, .clr_i(take_start), .wr_i(key_hs),
    .idx_i(kcnt_q[KI_W-1:0]), .byte_i(key_data_i), .data_o(kbuf)
  );

  hmac_byte_buf #(.NBYTES(BLK_BYTES)) u_msg_buf (
    .clk_i, .rst_ni, .clr_i(mbuf_clr), .wr_i(msg_hs),
    .idx_i(fill_q[BI_W-1:0]), .byte_i(msg_data_i), .data_o(mbuf)
  );

  hmac_pad_gen u_pad_gen (
    .key_blk_i(kbuf[KEY_W-1 -: BLK_W]), .key_dig_i(kdig_q), .long_i(key_long),
    .mode_i(mode_q), .ipad_o(ipad), .opad_o(opad)
  );

  // request fields, held stable through ST_WAIT
  always_comb begin
    req_block_o  = '0;
    req_state_o  = '0;
    req_count_o  = '0;
    req_nbytes_o = NB_W'(BLK_BYTES);
    req_last_o   = 1'b0;
    case (op_q)
      OP_KEY0: req_block_o = kbuf[KEY_W-1 -: BLK_W];
      OP_KEY1: begin
        req_block_o  = kbuf[KEY_W-BLK_W-1 -: BLK_W];
        req_state_o  = chain_q;
        req_count_o  = (LEN_W+1)'(BLK_BYTES);
        req_nbytes_o = NB_W'(klen_q - KL_W'(BLK_BYTES));
        req_last_o   = 1'b1;
      end
      OP_IPAD: req_block_o = ipad;
      OP_OPAD: req_block_o = opad;
      OP_MSG: begin
        req_block_o  = mbuf;
        req_state_o  = chain_q;
        req_count_o  = (LEN_W+1)'(BLK_BYTES) + {1'b0, base_q};
        req_nbytes_o = fill_q;
        req_last_o   = msg_last;
      end
      default: begin
        req_block_o  = {chain_q & mask, {(BLK_W-DIG_W){1'b0}}};
        req_state_o  = sout_q;
        req_count_o  = (LEN_W+1)'(BLK_BYTES);
        req_nbytes_o = NB_W'(dig_len(mode_q));
        req_last_o   = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;  op_q <= OP_IPAD;  mode_q <= '0;
      klen_q  <= '0;       kcnt_q <= '0;     mlen_q <= '0;
      base_q  <= '0;       fill_q <= '0;     chain_q <= '0;
      kdig_q  <= '0;       sin_q  <= '0;     sout_q <= '0;
      tag_q   <= '0;       done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          mode_q <= mode_i;  klen_q <= key_len_i;  mlen_q <= msg_len_i;
          kcnt_q <= '0;      base_q <= '0;         fill_q <= '0;
          kdig_q <= '0;
          op_q   <= OP_IPAD;
          state_q <= (key_len_i == '0) ? ST_REQ : ST_KEY;
        end
        ST_KEY: if (key_valid_i) begin
          kcnt_q <= kcnt_q + 1'b1;
          if (kcnt_q + 1'b1 == klen_q) begin
            op_q    <= key_long ? OP_KEY0 : OP_IPAD;
            state_q <= ST_REQ;
          end
        end
        ST_MSG: if (msg_valid_i) begin
          fill_q <= fill_q + 1'b1;
          if (fill_q == NB_W'(BLK_BYTES - 1) ||
              base_q + LEN_W'(fill_q) + 1'b1 == mlen_q) begin
            op_q    <= OP_MSG;
            state_q <= ST_REQ;
          end
        end
        ST_REQ: state_q <= ST_WAIT;
        ST_WAIT: if (rsp_valid_i) begin
          state_q <= ST_REQ;
          case (op_q)
            OP_KEY0: begin chain_q <= rsp_digest_i; op_q <= OP_KEY1; end
            OP_KEY1: begin kdig_q  <= rsp_digest_i; op_q <= OP_IPAD; end
            OP_IPAD: begin sin_q   <= rsp_digest_i; op_q <= OP_OPAD; end
            OP_OPAD: begin
              sout_q  <= rsp_digest_i;
              chain_q <= sin_q;
              op_q    <= OP_MSG;
              if (mlen_q != '0) state_q <= ST_MSG;
            end
            OP_MSG: begin
              chain_q <= rsp_digest_i;
              if (msg_last) op_q <= OP_OUT;
              else begin
                base_q  <= base_q + LEN_W'(fill_q);
                fill_q  <= '0;
                state_q <= ST_MSG;
              end
            end
            default: begin
              tag_q   <= rsp_digest_i & mask;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          endcase
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_valid_o = (state_q == ST_REQ);
  assign req_mode_o  = mode_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign tag_o       = tag_q;

  assert_req_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |=> !req_valid_o);
  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !rsp_valid_i) |=>
      ($stable(req_block_o) && $stable(req_state_o) && $stable(req_count_o) &&
       $stable(req_nbytes_o) && $stable(req_last_o)));
  assert_done_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_tag_zero_tail_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((tag_o & ~dig_mask(req_mode_o)) == '0));
  assert_stream_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({key_ready_o, msg_ready_o, req_valid_o}));
  assert_nbytes_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_nbytes_o <= NB_W'(BLK_BYTES)));
endmodule

// File: tb/hmac_seq_ctrl_bench.sv
module hmac_seq_ctrl_bench;
  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         start_i;
  logic [1:0]   mode_i;
  logic [7:0]   key_len_i;
  logic [31:0]  msg_len_i;
  logic         key_valid_i, msg_valid_i;
  logic [7:0]   key_data_i, msg_data_i;
  logic         key_ready_o, msg_ready_o;
  logic         req_valid_o, req_last_o;
  logic [511:0] req_block_o;
  logic [255:0] req_state_o, rsp_digest_i, tag_o;
  logic [32:0]  req_count_o;
  logic [6:0]   req_nbytes_o;
  logic [1:0]   req_mode_o;
  logic         rsp_valid_i, busy_o, done_o;

  always #10 clk_i = ~clk_i; // 50 MHz

  hmac_seq_ctrl u_hmac_seq_ctrl (
    .clk_i, .rst_ni, .start_i, .mode_i, .key_len_i, .msg_len_i,
    .key_valid_i, .key_data_i, .key_ready_o,
    .msg_valid_i, .msg_data_i, .msg_ready_o,
    .req_valid_o, .req_block_o, .req_state_o, .req_count_o,
    .req_nbytes_o, .req_last_o, .req_mode_o,
    .rsp_valid_i, .rsp_digest_i, .busy_o, .done_o, .tag_o
  );

  int n_tests = 0, n_fail = 0;
  logic [7:0] key_b [0:127];
  logic [7:0] msg_b [0:255];
  int klen_tb = 0, mlen_tb = 0, run_id = 0, seen_id = 0;
  int k_acc = 0, m_acc = 0, ops = 0, lat = 0;
  logic [15:0]  lf = 16'hace1;
  logic         eng_busy = 1'b0, prev_req = 1'b0;
  logic [511:0] c_blk;
  logic [255:0] c_st;
  logic [32:0]  c_cnt;
  logic [6:0]   c_nb;
  logic         c_last;
  logic [1:0]   c_md;

  task automatic chk(input bit ok, input string lbl, input logic [255:0] act, input logic [255:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", lbl, act, exp);
    end
  endtask

  // mock compression: every request field reaches the result
  function automatic logic [255:0] mf(input logic [255:0] st, input logic [511:0] blk,
                                      input logic [32:0] cnt, input logic [6:0] nb,
                                      input logic last, input logic [1:0] md);
    logic [255:0] x;
    x = {st[250:0], st[255:251]} + blk[511:256];
    x = x ^ {blk[254:0], blk[255]};
    x = x + {cnt, nb, last, md, 213'd0} + {213'd0, cnt, nb, last, md};
    x = x ^ (x >> 17) ^ 256'h9e3779b97f4a7c15;
    return x;
  endfunction

  function automatic int dlen(input logic [1:0] md);
    return (md == 2'd0) ? 20 : (md == 2'd1) ? 28 : 32;
  endfunction

  function automatic logic [255:0] dmask(input logic [1:0] md);
    return ~({256{1'b1}} >> (8 * dlen(md)));
  endfunction

  function automatic logic [511:0] pk_key(input int off, input int n);
    logic [511:0] b = '0;
    for (int i = 0; i < 64; i++) if (i < n) b[511-8*i -: 8] = key_b[off+i];
    return b;
  endfunction

  function automatic logic [511:0] pk_msg(input int off, input int n);
    logic [511:0] b = '0;
    for (int i = 0; i < 64; i++) if (i < n) b[511-8*i -: 8] = msg_b[off+i];
    return b;
  endfunction

  function automatic logic [255:0] ref_tag(input int kl, input int ml, input logic [1:0] md);
    logic [511:0] k0, blk;
    logic [255:0] d, si, so, ch, m;
    int base, n;
    logic last;
    m = dmask(md);
    if (kl > 64) begin
      d  = mf('0, pk_key(0, 64), 33'd0, 7'd64, 1'b0, md);
      d  = mf(d, pk_key(64, kl - 64), 33'd64, 7'(kl - 64), 1'b1, md);
      k0 = {d & m, 256'd0};
    end else k0 = pk_key(0, kl);
    si = mf('0, k0 ^ {64{8'h36}}, 33'd0, 7'd64, 1'b0, md);
    so = mf('0, k0 ^ {64{8'h5c}}, 33'd0, 7'd64, 1'b0, md);
    ch = si; base = 0; last = 1'b0;
    while (!last) begin
      n    = (ml - base > 64) ? 64 : ml - base;
      blk  = pk_msg(base, n);
      last = (base + n == ml);
      ch   = mf(ch, blk, 33'(64 + base), 7'(n), last, md);
      base = base + n;
    end
    blk = {ch & m, 256'd0};
    return mf(so, blk, 33'd64, 7'(dlen(md)), 1'b1, md) & m;
  endfunction

  // stream drivers and mock engine, all on the falling edge
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      key_valid_i = 1'b0; msg_valid_i = 1'b0; key_data_i = '0; msg_data_i = '0;
      rsp_valid_i = 1'b0; rsp_digest_i = '0; eng_busy = 1'b0; prev_req = 1'b0;
    end else begin
      if (seen_id != run_id) begin seen_id = run_id; k_acc = 0; m_acc = 0; ops = 0; end
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      key_valid_i = lf[0] | lf[3];
      key_data_i  = (k_acc < klen_tb) ? key_b[k_acc] : 8'hee;
      if (key_valid_i && key_ready_o) k_acc++;
      msg_valid_i = lf[1] | lf[5];
      msg_data_i  = (m_acc < mlen_tb) ? msg_b[m_acc] : 8'h77;
      if (msg_valid_i && msg_ready_o) m_acc++;
      rsp_valid_i = 1'b0;
      if (req_valid_o) begin
        if (prev_req) chk(1'b0, "R9 request longer than one cycle", 256'd1, 256'd0);
        c_blk = req_block_o; c_st = req_state_o; c_cnt = req_count_o;
        c_nb = req_nbytes_o; c_last = req_last_o; c_md = req_mode_o;
        ops++; lat = 1 + ops % 3; eng_busy = 1'b1;
      end else if (eng_busy) begin
        if (lat > 0) lat--;
        else begin
          if (!(req_block_o == c_blk && req_state_o == c_st && req_count_o == c_cnt &&
                req_nbytes_o == c_nb && req_last_o == c_last))
            chk(1'b0, "R9 request fields not held", req_state_o, c_st);
          rsp_digest_i = mf(c_st, c_blk, c_cnt, c_nb, c_last, c_md);
          rsp_valid_i  = 1'b1;
          eng_busy     = 1'b0;
        end
      end
      prev_req = req_valid_o;
    end
  end

  task automatic run(input int kl, input int ml, input int md, input bit poke, input int s);
    logic [255:0] exp, m;
    int exp_ops, cyc, L;
    for (int i = 0; i < 128; i++) key_b[i] = 8'((i * 29 + s * 71 + 3) ^ (i >> 2));
    for (int i = 0; i < 256; i++) msg_b[i] = 8'((i * 53 + s * 17 + 9) ^ (i >> 3));
    klen_tb = kl; mlen_tb = ml; run_id++;
    L = dlen(2'(md)); m = dmask(2'(md));
    exp = ref_tag(kl, ml, 2'(md));
    exp_ops = (kl > 64 ? 2 : 0) + 2 + (ml == 0 ? 1 : (ml + 63) / 64) + 1;
    @(negedge clk_i);
    start_i = 1'b1; mode_i = 2'(md); key_len_i = 8'(kl); msg_len_i = 32'(ml);
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o, "R2 busy after start", 256'(busy_o), 256'd1);
    if (poke) begin
      repeat (3) @(negedge clk_i);
      start_i = 1'b1; mode_i = ~2'(md); key_len_i = 8'd3; msg_len_i = 32'd0;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    cyc = 0;
    while (!done_o && cyc < 20000) begin @(negedge clk_i); cyc++; end
    if (cyc >= 20000) chk(1'b0, "R2 run watchdog expired", 256'(cyc), 256'd0);
    chk(tag_o == exp, kl > 64 ? "R4 R5 R6 R10 tag long key" : "R3 R5 R6 R10 tag short key", tag_o, exp);
    chk((tag_o & ~m) == '0, "R8 tag bytes past L zero", tag_o & ~m, 256'd0);
    chk(ops == exp_ops, "R3 R4 R6 operation count", 256'(ops), 256'(exp_ops));
    chk(c_cnt == 33'd64 && c_nb == 7'(L) && c_last && c_st != '0,
        "R7 outer request count/nbytes/last", {c_cnt, c_nb, c_last}, {33'd64, 7'(L), 1'b1});
    chk(k_acc == kl, "R11 key bytes taken", 256'(k_acc), 256'(kl));
    chk(m_acc == ml, "R11 message bytes taken", 256'(m_acc), 256'(ml));
    chk(!busy_o, "R2 idle with done", 256'(busy_o), 256'd0);
    @(negedge clk_i);
    chk(!done_o, "R2 done single cycle", 256'(done_o), 256'd0);
    chk(k_acc == kl && m_acc == ml && !key_ready_o && !msg_ready_o,
        "R11 no bytes after done", 256'(k_acc + m_acc), 256'(kl + ml));
  endtask

  initial begin
    int kls [5] = '{0, 5, 64, 65, 128};
    int mls [5] = '{0, 1, 64, 65, 129};
    int s;
    rst_ni = 1'b0; start_i = 1'b0; mode_i = '0; key_len_i = '0; msg_len_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o && !req_valid_o && !key_ready_o && !msg_ready_o && tag_o == '0,
        "R1 reset state", {busy_o, done_o, req_valid_o, key_ready_o, msg_ready_o}, 256'd0);
    s = 0;
    for (int md = 0; md < 4; md++)
      for (int ki = 0; ki < 5; ki++)
        for (int mi = 0; mi < 5; mi++) begin
          run(kls[ki], mls[mi], md, (kls[ki] >= 64) && ((ki + mi + md) % 3 == 0), s);
          s++;
        end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL R2 global watchdog act=hung exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule